// File: doc/BRIEF.md
# Write-Drain Mode Command Flush Controller

This block sits inside a DRAM channel controller that keeps one short command slot per rank and bank. Each slot is empty, holds a lone column command (read or write), or holds an activate followed by a column command. An outside policy decides when the channel should favour writes. This block reacts to the change of that mode input. When the mode switches, it looks at every slot in the same cycle. A lone column command of the type that just lost priority has already committed, so it is allowed to finish. It is flagged as a drain and counted. An activate-plus-column pair of that type has not committed yet, so it is cancelled and its request tag is handed back through a re-queue port.

A scheduler fills slots through a load port and pops their head commands through an issue port. It can read one slot at a time through a peek port. While the drain counters are nonzero it can hold back the other command type. The block also measures each write-drain episode. It reports the reads and writes issued during the episode and the episode length in cycles. It also reports the idle gap between the end of one episode and the start of the next.

Top module: `wdf_flush_ctrl`

## Requirements
- R1: Slot kind codes are 0 = empty, 1 = lone column, 2 = activate plus column. A load is taken only by an empty slot; a load into an occupied slot is ignored. An issue turns kind 2 into kind 1, with the same type and tag and the drain flag cleared, and turns kind 1 into kind 0.
- R2: On entry to write-drain mode (mode input high while the registered mode is low), every lone read gets its drain flag set. The reads-to-drain counter is loaded with the number of such slots. A lone write keeps its state.
- R3: On entry, every activate-plus-read slot becomes empty and its tag is queued for re-queue. Activate-plus-write slots are kept.
- R4: With read bypass enabled, an activate-plus-read slot whose bank write queue is reported empty is kept on entry. Bypass has no effect on exit.
- R5: On exit from write-drain mode, every lone write is flagged and counted into the writes-to-drain counter. Every activate-plus-write slot is cancelled and re-queued. Lone reads and activate-plus-read slots are kept.
- R6: In the cycle where the mode changes, issue and load requests are ignored.
- R7: The re-queue port presents one entry at a time. Entries cancelled on the same edge leave in ascending slot order. An entry is held stable until it is accepted with the ready input.
- R8: Issuing a drain-flagged read while in the mode decrements the reads-to-drain counter. Issuing a drain-flagged write while out of the mode decrements the writes-to-drain counter. Each pending output is high while its counter is nonzero, and neither counter is ever decremented at zero.
- R9: Column commands issued while in the mode are counted separately as reads and writes. Both counts are reported and cleared when the mode exits.
- R10: One cycle after an exit, the episode-valid output pulses and the episode length equals the number of clock edges from the entry edge to the exit edge.
- R11: One cycle after an entry, the gap-valid output pulses with the number of edges since the last exit edge. There is no pulse before the first exit after reset.
- R12: After reset all slots are empty, the re-queue port is idle, both pending outputs are low and no report pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_mode_i | input | 1 | Write-drain mode request from the policy |
| read_bypass_en | input | 1 | Keeps activate-plus-read slots whose write queue is empty |
| wq_empty | input | SLOTS | Per-slot flag: that bank's write queue is empty |
| load_valid | input | 1 | Load a command into a slot |
| load_slot | input | SLOT_W | Slot index for the load |
| load_act | input | 1 | 1 = activate plus column, 0 = lone column |
| load_is_write | input | 1 | Column type of the load, 1 = write |
| load_tag | input | TAG_W | Request tag of the load |
| issue_valid | input | 1 | Pop the head command of a slot |
| issue_slot | input | SLOT_W | Slot index for the issue |
| peek_slot | input | SLOT_W | Slot to observe |
| peek_kind | output | 2 | Kind code of the observed slot |
| peek_is_write | output | 1 | Column type of the observed slot |
| peek_drain | output | 1 | Drain flag of the observed slot |
| peek_tag | output | TAG_W | Tag of the observed slot |
| rq_valid | output | 1 | A cancelled request waits |
| rq_ready | input | 1 | Consumer accepts the re-queue entry |
| rq_slot | output | SLOT_W | Slot of the cancelled request |
| rq_tag | output | TAG_W | Tag of the cancelled request |
| rd_drain_pending | output | 1 | Reads-to-drain counter nonzero |
| wr_drain_pending | output | 1 | Writes-to-drain counter nonzero |
| ep_valid | output | 1 | Episode report pulse |
| ep_len | output | TS_W | Episode length in cycles |
| ep_reads | output | CNT_W | Reads issued in the episode |
| ep_writes | output | CNT_W | Writes issued in the episode |
| gap_valid | output | 1 | Gap report pulse |
| gap_len | output | TS_W | Cycles from last exit to this entry |

## Verification
The slot updates and drain counters change on the clock edge that sees the mode change. The slot contents, pending outputs and the head of the re-queue port can therefore be read in the same cycle, half a period after that edge. The episode and gap reports are registered on the same edge and last one cycle. The bench reads them half a period after the mode-change edge and again one cycle later to confirm the pulse has ended. Inputs change on falling edges, so the bench knows the exact edge where entry or exit happens. Expected lengths and gaps are counted in edges from those points.

// File: rtl/wdf_pkg.sv
package wdf_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_COL     = 2'd1,
        SLOT_ACT_COL = 2'd2
    } slot_kind_e;

    // Head pop: the activate leaves first, then the column command.
    function automatic slot_kind_e kind_after_issue(slot_kind_e k);
        case (k)
            SLOT_ACT_COL: return SLOT_COL;
            default:      return SLOT_EMPTY;
        endcase
    endfunction

endpackage

// File: rtl/wdf_slot.sv
module wdf_slot
    import wdf_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             leave,
    input  logic             bypass_en,
    input  logic             wq_empty,
    input  logic             load_en,
    input  logic             load_act,
    input  logic             load_wr,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             issue_en,
    output slot_kind_e       kind_o,
    output logic             is_wr_o,
    output logic             drain_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             cancel_o,
    output logic             lone_rd_mark_o,
    output logic             lone_wr_mark_o
);

    slot_kind_e       kind_q;
    logic             wr_q;
    logic             drain_q;
    logic [TAG_W-1:0] tag_q;

    logic pair_rd, pair_wr, lone_rd, lone_wr;

    always_comb begin
        pair_rd = (kind_q == SLOT_ACT_COL) && !wr_q;
        pair_wr = (kind_q == SLOT_ACT_COL) &&  wr_q;
        lone_rd = (kind_q == SLOT_COL) && !wr_q;
        lone_wr = (kind_q == SLOT_COL) &&  wr_q;
        cancel_o = (enter && pair_rd && !(bypass_en && wq_empty))
                || (leave && pair_wr);
        lone_rd_mark_o = enter && lone_rd;
        lone_wr_mark_o = leave && lone_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= SLOT_EMPTY;
            wr_q    <= 1'b0;
            drain_q <= 1'b0;
            tag_q   <= '0;
        end else if (enter || leave) begin
            if (lone_rd_mark_o || lone_wr_mark_o) drain_q <= 1'b1;
            if (cancel_o) begin
                kind_q  <= SLOT_EMPTY;
                drain_q <= 1'b0;
            end
        end else if (issue_en && kind_q != SLOT_EMPTY) begin
            kind_q  <= kind_after_issue(kind_q);
            drain_q <= 1'b0;
        end else if (load_en && kind_q == SLOT_EMPTY) begin
            kind_q  <= load_act ? SLOT_ACT_COL : SLOT_COL;
            wr_q    <= load_wr;
            drain_q <= 1'b0;
            tag_q   <= load_tag;
        end
    end

    assign kind_o  = kind_q;
    assign is_wr_o = wr_q;
    assign drain_o = drain_q;
    assign tag_o   = tag_q;

    // R1
    col_issue_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_en && kind_q == SLOT_COL) |=> (kind_q == SLOT_EMPTY));

    // R3
    cancel_clears_slot_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_o |=> (kind_q == SLOT_EMPTY));

endmodule

// File: rtl/wdf_requeue_fifo.sv
module wdf_requeue_fifo #(
    parameter int SLOTS  = 8,
    parameter int TAG_W  = 6,
    parameter int DEPTH  = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOTS-1:0]  push,
    input  logic [TAG_W-1:0]  push_tag [SLOTS],
    input  logic              ready,
    output logic              valid,
    output logic [SLOT_W-1:0] head_slot,
    output logic [TAG_W-1:0]  head_tag
);

    logic [SLOT_W-1:0] mem_slot [DEPTH];
    logic [TAG_W-1:0]  mem_tag  [DEPTH];
    logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [PW:0]       count_q;
    logic [PW:0]       n_push;
    logic [PW-1:0]     wr_idx [SLOTS];
    logic              pop;

    always_comb begin
        n_push = '0;
        for (int i = 0; i < SLOTS; i++) begin
            wr_idx[i] = wr_ptr_q + n_push[PW-1:0];
            if (push[i]) n_push = n_push + 1'b1;
        end
    end

    assign valid     = (count_q != '0);
    assign pop       = valid && ready;
    assign head_slot = mem_slot[rd_ptr_q];
    assign head_tag  = mem_tag[rd_ptr_q];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (push[i]) begin
                mem_slot[wr_idx[i]] <= SLOT_W'(i);
                mem_tag[wr_idx[i]]  <= push_tag[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + n_push[PW-1:0];
            if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
            count_q  <= count_q + n_push - {{PW{1'b0}}, pop};
        end
    end

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(head_slot) && $stable(head_tag)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(count_q) + int'(n_push) <= DEPTH));

endmodule

// File: rtl/wdf_episode_stats.sv
module wdf_episode_stats #(
    parameter int TS_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             leave,
    input  logic             rd_issued,
    input  logic             wr_issued,
    output logic             ep_valid,
    output logic [TS_W-1:0]  ep_len,
    output logic [CNT_W-1:0] ep_reads,
    output logic [CNT_W-1:0] ep_writes,
    output logic             gap_valid,
    output logic [TS_W-1:0]  gap_len
);

    logic [TS_W-1:0]  cyc_q, entry_ts_q, exit_ts_q;
    logic             have_exit_q;
    logic [CNT_W-1:0] rd_n_q, wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q       <= '0;
            entry_ts_q  <= '0;
            exit_ts_q   <= '0;
            have_exit_q <= 1'b0;
            rd_n_q      <= '0;
            wr_n_q      <= '0;
            ep_valid    <= 1'b0;
            ep_len      <= '0;
            ep_reads    <= '0;
            ep_writes   <= '0;
            gap_valid   <= 1'b0;
            gap_len     <= '0;
        end else begin
            cyc_q     <= cyc_q + 1'b1;
            ep_valid  <= leave;
            gap_valid <= enter && have_exit_q;
            if (enter) begin
                entry_ts_q <= cyc_q;
                gap_len    <= cyc_q - exit_ts_q;
                rd_n_q     <= '0;
                wr_n_q     <= '0;
            end else if (leave) begin
                exit_ts_q   <= cyc_q;
                have_exit_q <= 1'b1;
                ep_len      <= cyc_q - entry_ts_q;
                ep_reads    <= rd_n_q;
                ep_writes   <= wr_n_q;
                rd_n_q      <= '0;
                wr_n_q      <= '0;
            end else begin
                if (rd_issued) rd_n_q <= rd_n_q + 1'b1;
                if (wr_issued) wr_n_q <= wr_n_q + 1'b1;
            end
        end
    end

    // R11
    gap_after_exit_chk: assert property (@(posedge clk) disable iff (rst)
        gap_valid |-> $past(have_exit_q));

    // R10
    ep_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        ep_valid |=> !ep_valid);

endmodule

// File: rtl/wdf_flush_ctrl.sv
module wdf_flush_ctrl
    import wdf_pkg::*;
#(
    parameter int RANKS = 2,
    parameter int BANKS = 4,
    parameter int TAG_W = 6,
    parameter int TS_W  = 16,
    parameter int CNT_W = 8,
    localparam int SLOTS  = RANKS * BANKS,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int DW     = $clog2(SLOTS + 1),
    localparam int RQ_DEPTH = 2 * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drain_mode_i,
    input  logic              read_bypass_en,
    input  logic [SLOTS-1:0]  wq_empty,
    input  logic              load_valid,
    input  logic [SLOT_W-1:0] load_slot,
    input  logic              load_act,
    input  logic              load_is_write,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic              issue_valid,
    input  logic [SLOT_W-1:0] issue_slot,
    input  logic [SLOT_W-1:0] peek_slot,
    output logic [1:0]        peek_kind,
    output logic              peek_is_write,
    output logic              peek_drain,
    output logic [TAG_W-1:0]  peek_tag,
    output logic              rq_valid,
    input  logic              rq_ready,
    output logic [SLOT_W-1:0] rq_slot,
    output logic [TAG_W-1:0]  rq_tag,
    output logic              rd_drain_pending,
    output logic              wr_drain_pending,
    output logic              ep_valid,
    output logic [TS_W-1:0]   ep_len,
    output logic [CNT_W-1:0]  ep_reads,
    output logic [CNT_W-1:0]  ep_writes,
    output logic              gap_valid,
    output logic [TS_W-1:0]   gap_len
);

    logic mode_q, enter, leave, mode_edge;
    assign enter     =  drain_mode_i && !mode_q;
    assign leave     = !drain_mode_i &&  mode_q;
    assign mode_edge = enter || leave;

    slot_kind_e       kind_a  [SLOTS];
    logic             wr_a    [SLOTS];
    logic             drain_a [SLOTS];
    logic [TAG_W-1:0] tag_a   [SLOTS];
    logic [SLOTS-1:0] cancel_v, lone_rd_v, lone_wr_v;

    logic issue_fire, load_fire;
    assign issue_fire = issue_valid && !mode_edge;
    assign load_fire  = load_valid  && !mode_edge;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        wdf_slot #(.TAG_W(TAG_W)) u_slot (
            .clk            (clk),
            .rst            (rst),
            .enter          (enter),
            .leave          (leave),
            .bypass_en      (read_bypass_en),
            .wq_empty       (wq_empty[s]),
            .load_en        (load_fire && load_slot == SLOT_W'(s)),
            .load_act       (load_act),
            .load_wr        (load_is_write),
            .load_tag       (load_tag),
            .issue_en       (issue_fire && issue_slot == SLOT_W'(s)),
            .kind_o         (kind_a[s]),
            .is_wr_o        (wr_a[s]),
            .drain_o        (drain_a[s]),
            .tag_o          (tag_a[s]),
            .cancel_o       (cancel_v[s]),
            .lone_rd_mark_o (lone_rd_v[s]),
            .lone_wr_mark_o (lone_wr_v[s])
        );
    end

    // Column command leaving a slot this cycle
    logic col_issue, sel_wr, sel_drain;
    assign col_issue = issue_fire && (kind_a[issue_slot] == SLOT_COL);
    assign sel_wr    = wr_a[issue_slot];
    assign sel_drain = drain_a[issue_slot];

    logic rd_dec, wr_dec;
    assign rd_dec = col_issue && sel_drain && !sel_wr &&  mode_q;
    assign wr_dec = col_issue && sel_drain &&  sel_wr && !mode_q;

    logic [DW-1:0] rd_cnt_q, wr_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= 1'b0;
            rd_cnt_q <= '0;
            wr_cnt_q <= '0;
        end else begin
            mode_q <= drain_mode_i;
            if (enter)
                rd_cnt_q <= DW'($countones(lone_rd_v));
            else if (rd_dec && rd_cnt_q != '0)
                rd_cnt_q <= rd_cnt_q - 1'b1;
            if (leave)
                wr_cnt_q <= DW'($countones(lone_wr_v));
            else if (wr_dec && wr_cnt_q != '0)
                wr_cnt_q <= wr_cnt_q - 1'b1;
        end
    end

    assign rd_drain_pending = (rd_cnt_q != '0);
    assign wr_drain_pending = (wr_cnt_q != '0);

    assign peek_kind     = kind_a[peek_slot];
    assign peek_is_write = wr_a[peek_slot];
    assign peek_drain    = drain_a[peek_slot];
    assign peek_tag      = tag_a[peek_slot];

    wdf_requeue_fifo #(
        .SLOTS (SLOTS),
        .TAG_W (TAG_W),
        .DEPTH (RQ_DEPTH)
    ) u_requeue (
        .clk       (clk),
        .rst       (rst),
        .push      (cancel_v),
        .push_tag  (tag_a),
        .ready     (rq_ready),
        .valid     (rq_valid),
        .head_slot (rq_slot),
        .head_tag  (rq_tag)
    );

    wdf_episode_stats #(
        .TS_W  (TS_W),
        .CNT_W (CNT_W)
    ) u_stats (
        .clk       (clk),
        .rst       (rst),
        .enter     (enter),
        .leave     (leave),
        .rd_issued (col_issue && !sel_wr && mode_q),
        .wr_issued (col_issue &&  sel_wr && mode_q),
        .ep_valid  (ep_valid),
        .ep_len    (ep_len),
        .ep_reads  (ep_reads),
        .ep_writes (ep_writes),
        .gap_valid (gap_valid),
        .gap_len   (gap_len)
    );

    // R8
    rd_drain_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_dec |-> (rd_cnt_q != '0));

    // R8
    wr_drain_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dec |-> (wr_cnt_q != '0));

    // R6
    edge_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
        mode_edge |-> !col_issue);

endmodule

// File: tb/wdf_flush_ctrl_bench.sv
module wdf_flush_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = 3;
    localparam int TAG_W  = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic              drain_mode_i;
    logic              read_bypass_en;
    logic [SLOTS-1:0]  wq_empty;
    logic              load_valid;
    logic [SLOT_W-1:0] load_slot;
    logic              load_act;
    logic              load_is_write;
    logic [TAG_W-1:0]  load_tag;
    logic              issue_valid;
    logic [SLOT_W-1:0] issue_slot;
    logic [SLOT_W-1:0] peek_slot;
    logic [1:0]        peek_kind;
    logic              peek_is_write;
    logic              peek_drain;
    logic [TAG_W-1:0]  peek_tag;
    logic              rq_valid;
    logic              rq_ready;
    logic [SLOT_W-1:0] rq_slot;
    logic [TAG_W-1:0]  rq_tag;
    logic              rd_drain_pending;
    logic              wr_drain_pending;
    logic              ep_valid;
    logic [15:0]       ep_len;
    logic [7:0]        ep_reads;
    logic [7:0]        ep_writes;
    logic              gap_valid;
    logic [15:0]       gap_len;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdf_flush_ctrl u_wdf_flush_ctrl (
        .clk (clk), .rst (rst), .drain_mode_i (drain_mode_i),
        .read_bypass_en (read_bypass_en), .wq_empty (wq_empty),
        .load_valid (load_valid), .load_slot (load_slot), .load_act (load_act),
        .load_is_write (load_is_write), .load_tag (load_tag),
        .issue_valid (issue_valid), .issue_slot (issue_slot),
        .peek_slot (peek_slot), .peek_kind (peek_kind),
        .peek_is_write (peek_is_write), .peek_drain (peek_drain),
        .peek_tag (peek_tag), .rq_valid (rq_valid), .rq_ready (rq_ready),
        .rq_slot (rq_slot), .rq_tag (rq_tag),
        .rd_drain_pending (rd_drain_pending), .wr_drain_pending (wr_drain_pending),
        .ep_valid (ep_valid), .ep_len (ep_len), .ep_reads (ep_reads),
        .ep_writes (ep_writes), .gap_valid (gap_valid), .gap_len (gap_len)
    );

    // {dir(1=exit), act, wr, bypass, wq_empty, exp_kind[1:0], exp_drain, exp_cancel, exp_pending}
    localparam logic [9:0] VEC [11] = '{
        10'b0_0_0_0_0_01_1_0_1,   // R2 lone read flagged
        10'b0_0_1_0_0_01_0_0_0,   // R2 lone write untouched
        10'b0_1_0_0_0_00_0_1_0,   // R3 act+read cancelled
        10'b0_1_0_1_1_10_0_0_0,   // R4 bypass keeps pair
        10'b0_1_0_1_0_00_0_1_0,   // R4 bypass, write queue busy
        10'b0_1_1_0_0_10_0_0_0,   // R3 act+write kept
        10'b1_0_1_0_0_01_1_0_1,   // R5 lone write flagged
        10'b1_0_0_0_0_01_0_0_0,   // R5 lone read untouched
        10'b1_1_1_0_0_00_0_1_0,   // R5 act+write cancelled
        10'b1_1_0_0_0_10_0_0_0,   // R5 act+read kept
        10'b1_1_1_1_1_00_0_1_0    // R4 bypass ignored on exit
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drain_mode_i = 1'b0; read_bypass_en = 1'b0; wq_empty = '0;
        load_valid = 1'b0; load_slot = '0; load_act = 1'b0;
        load_is_write = 1'b0; load_tag = '0;
        issue_valid = 1'b0; issue_slot = '0; peek_slot = '0; rq_ready = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic load(input int s, input bit act, input bit wr, input int tag);
        load_valid = 1'b1; load_slot = SLOT_W'(s); load_act = act;
        load_is_write = wr; load_tag = TAG_W'(tag);
        tick();
        load_valid = 1'b0;
    endtask

    task automatic issue(input int s);
        issue_valid = 1'b1; issue_slot = SLOT_W'(s);
        tick();
        issue_valid = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        drain_mode_i = m;
        tick();
    endtask

    task automatic peek(input int s);
        peek_slot = SLOT_W'(s);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R12 reset state
        do_reset();
        peek(3);
        chk("R12 kind", int'(peek_kind), 0);
        chk("R12 rq_valid", int'(rq_valid), 0);
        chk("R12 rd_pending", int'(rd_drain_pending), 0);
        chk("R12 wr_pending", int'(wr_drain_pending), 0);
        chk("R12 ep_valid", int'(ep_valid), 0);
        chk("R12 gap_valid", int'(gap_valid), 0);

        // Table of single-slot flush cases
        for (int v = 0; v < 11; v++) begin
            logic [9:0] e;
            e = VEC[v];
            do_reset();
            read_bypass_en = e[6];
            wq_empty[0] = e[5];
            if (e[9]) set_mode(1'b1);
            load(0, e[8], e[7], 10 + v);
            set_mode(!e[9]);
            peek(0);
            chk("R2-5 table kind", int'(peek_kind), int'(e[4:3]));
            chk("R2-5 table drain", int'(peek_drain), int'(e[2]));
            chk("R3 table cancel", int'(rq_valid), int'(e[1]));
            if (e[1]) chk("R7 table tag", int'(rq_tag), 10 + v);
            chk("R8 table pending",
                int'(e[9] ? wr_drain_pending : rd_drain_pending), int'(e[0]));
        end

        // R1 load and issue
        do_reset();
        load(2, 1'b1, 1'b0, 3);
        load(2, 1'b0, 1'b1, 9);
        peek(2);
        chk("R1 busy load ignored kind", int'(peek_kind), 2);
        chk("R1 busy load ignored tag", int'(peek_tag), 3);
        chk("R1 busy load ignored type", int'(peek_is_write), 0);
        issue(2);
        chk("R1 pop activate", int'(peek_kind), 1);
        issue(2);
        chk("R1 pop column", int'(peek_kind), 0);

        // R7 several cancels on one edge, ascending slot order
        do_reset();
        load(5, 1'b1, 1'b0, 21);
        load(1, 1'b1, 1'b0, 22);
        load(3, 1'b1, 1'b0, 23);
        set_mode(1'b1);
        chk("R7 first slot", int'(rq_slot), 1);
        chk("R7 first tag", int'(rq_tag), 22);
        tick();
        chk("R7 held slot", int'(rq_slot), 1);
        rq_ready = 1'b1;
        tick();
        chk("R7 second slot", int'(rq_slot), 3);
        chk("R7 second tag", int'(rq_tag), 23);
        tick();
        chk("R7 third slot", int'(rq_slot), 5);
        chk("R7 third tag", int'(rq_tag), 21);
        tick();
        rq_ready = 1'b0;
        chk("R7 drained", int'(rq_valid), 0);

        // R8 reads-to-drain
        do_reset();
        load(0, 1'b0, 1'b0, 1);
        load(1, 1'b0, 1'b0, 2);
        set_mode(1'b1);
        chk("R8 rd pending set", int'(rd_drain_pending), 1);
        issue(0);
        chk("R8 rd pending after one", int'(rd_drain_pending), 1);
        issue(1);
        chk("R8 rd pending cleared", int'(rd_drain_pending), 0);
        set_mode(1'b0);
        chk("R8 wr pending none", int'(wr_drain_pending), 0);

        // R8 writes-to-drain
        do_reset();
        set_mode(1'b1);
        load(4, 1'b0, 1'b1, 7);
        set_mode(1'b0);
        chk("R8 wr pending set", int'(wr_drain_pending), 1);
        issue(4);
        chk("R8 wr pending cleared", int'(wr_drain_pending), 0);

        // R6 issue and load ignored on the mode-change edge
        do_reset();
        load(0, 1'b0, 1'b0, 4);
        drain_mode_i = 1'b1;
        issue_valid = 1'b1; issue_slot = 3'd0;
        load_valid = 1'b1; load_slot = 3'd1; load_act = 1'b0;
        load_is_write = 1'b1; load_tag = 6'd8;
        tick();
        issue_valid = 1'b0; load_valid = 1'b0;
        peek(0);
        chk("R6 issue blocked kind", int'(peek_kind), 1);
        chk("R6 issue blocked drain", int'(peek_drain), 1);
        peek(1);
        chk("R6 load blocked", int'(peek_kind), 0);

        // R9 R10 R11 episode statistics
        do_reset();
        set_mode(1'b1);                         // entry edge k
        chk("R11 no gap before first exit", int'(gap_valid), 0);
        load(0, 1'b0, 1'b0, 1);
        load(1, 1'b0, 1'b0, 2);
        load(2, 1'b0, 1'b1, 3);
        issue(0);
        issue(1);
        issue(2);
        tick();
        set_mode(1'b0);                         // exit edge k+8
        chk("R10 ep_valid", int'(ep_valid), 1);
        chk("R10 ep_len", int'(ep_len), 8);
        chk("R9 ep_reads", int'(ep_reads), 2);
        chk("R9 ep_writes", int'(ep_writes), 1);
        tick();
        chk("R10 ep_valid one cycle", int'(ep_valid), 0);
        repeat (3) tick();
        set_mode(1'b1);                         // entry 5 edges after exit
        chk("R11 gap_valid", int'(gap_valid), 1);
        chk("R11 gap_len", int'(gap_len), 5);
        set_mode(1'b0);
        chk("R10 short ep_len", int'(ep_len), 1);
        chk("R9 reads cleared", int'(ep_reads), 0);
        chk("R9 writes cleared", int'(ep_writes), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule